// File: doc/BRIEF.md
# PS/2 Mouse Stream Controller

This block runs above a byte-level PS/2 host transceiver and brings a mouse into stream reporting. A pulse on the enable input makes it hand the enable-reporting command byte to the transceiver. It then waits for the device's acknowledge byte. From then on it groups every three received bytes into one movement packet.

Each finished packet updates three button flags. It also adds the signed X and Y movement to two running displacement registers. Each register is split into a low and a high byte so that a four-digit hex display can be driven directly. A clear input zeroes both registers without touching the buttons. Bytes that arrive before the acknowledge are dropped, and so are bytes that arrive while the command is still pending. Commands that carry a second argument byte are not supported.

Top module: `ps2_mouse_stream`

## Requirements
- R1: After reset the displacement outputs read zero, all three button flags are low, `tx_valid_o` is low and no received byte is decoded.
- R2: An `enable_i` pulse, taken while idle or streaming, raises `tx_valid_o` in the next cycle with `tx_data_o` = 0xF4. The request is held until a cycle with `tx_ready_i` high, and drops in the cycle after.
- R3: Received bytes have no effect on any output while the block is idle, while the command is pending, or while it is waiting for the acknowledge.
- R4: While waiting for the acknowledge, only a byte equal to 0xFA is accepted, and it is consumed rather than decoded. Other bytes are dropped. The next three bytes after it form the first packet.
- R5: When the third byte of a packet is taken, the first byte's bit 0, bit 1 and bit 2 set the left, right and middle flags. The flags hold that value until the next packet completes.
- R6: Each completed packet adds the 9-bit signed value {byte0 bit 4, byte 1} to the 16-bit X register, modulo 2^16.
- R7: Each completed packet adds the 9-bit signed value {byte0 bit 5, byte 2} to the 16-bit Y register, modulo 2^16.
- R8: `clear_i` zeroes both displacement registers in the next cycle and leaves the button flags unchanged. When it coincides with a completing packet, the result is still zero.
- R9: `x_lo_o`/`y_lo_o` present bits 7:0 and `x_hi_o`/`y_hi_o` bits 15:8 of the X and Y registers.
- R10: An `enable_i` pulse during streaming discards any partial packet and requires a fresh acknowledge before decoding resumes. An `enable_i` pulse while the command or acknowledge is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Request to start stream reporting |
| clear_i | input | 1 | Zero both displacement registers |
| rx_valid_i | input | 1 | Received byte strobe from transceiver |
| rx_data_i | input | 8 | Received byte |
| tx_ready_i | input | 1 | Transceiver accepts the command byte |
| tx_valid_o | output | 1 | Command byte pending |
| tx_data_o | output | 8 | Command byte (0xF4) |
| btn_left_o | output | 1 | Left button flag |
| btn_right_o | output | 1 | Right button flag |
| btn_mid_o | output | 1 | Middle button flag |
| x_lo_o | output | 8 | X displacement bits 7:0 |
| x_hi_o | output | 8 | X displacement bits 15:8 |
| y_lo_o | output | 8 | Y displacement bits 7:0 |
| y_hi_o | output | 8 | Y displacement bits 15:8 |

## Verification
A packet byte counter that has slipped by one shows up within a single packet. The button flags take movement bits, and X takes Y's byte, in the output sampled right after the next third byte. A link state that opened too early or closed too late shows up as displacement changing after bytes that should have been dropped, or failing to change after a valid packet. The bench checks the outputs after every packet. A missed sign extension or a wrong carry shows up only as the registers accumulate, so a long run of maximum-magnitude packets drives both registers through wrap-around.

// File: rtl/ps2m_pkg.sv
package ps2m_pkg;
  localparam logic [7:0] CMD_ENABLE = 8'hF4;
  localparam logic [7:0] RSP_ACK    = 8'hFA;
  localparam int MOV_W = 9;
  localparam int NUM_BTN = 3;
  localparam int BIT_XSIGN = 4;
  localparam int BIT_YSIGN = 5;
  localparam int PKT_LEN = 3;

  typedef enum logic [1:0] {
    LS_IDLE, LS_SEND, LS_WAIT, LS_STREAM
  } link_state_e;
endpackage

// File: rtl/ps2m_link_fsm.sv
module ps2m_link_fsm
  import ps2m_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       tx_ready_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       stream_o
);
  link_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LS_IDLE:   if (enable_i) state_d = LS_SEND;
      LS_SEND:   if (tx_ready_i) state_d = LS_WAIT;
      LS_WAIT:   if (rx_valid_i && rx_data_i == RSP_ACK) state_d = LS_STREAM;
      LS_STREAM: if (enable_i) state_d = LS_SEND;
      default:   state_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LS_IDLE;
    else         state_q <= state_d;
  end

  assign tx_valid_o = (state_q == LS_SEND);
  assign tx_data_o  = CMD_ENABLE;
  // restart from streaming blocks decode in the same cycle
  assign stream_o   = (state_q == LS_STREAM) && !enable_i;

  p_tx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o);
  p_tx_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i |=> !tx_valid_o);
  p_ack_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == LS_STREAM) |-> $past(rx_valid_i && rx_data_i == RSP_ACK));
endmodule

// File: rtl/ps2m_pkt_asm.sv
module ps2m_pkt_asm
  import ps2m_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    active_i,
  input  logic                    rx_valid_i,
  input  logic [7:0]              rx_data_i,
  output logic                    pkt_valid_o,
  output logic [NUM_BTN-1:0]      btn_o,
  output logic [MOV_W-1:0]        dx_o,
  output logic [MOV_W-1:0]        dy_o
);
  localparam int IDX_W = $clog2(PKT_LEN);

  logic [IDX_W-1:0]   idx_q;
  logic [NUM_BTN-1:0] btn_hold_q, btn_q;
  logic               xs_q, ys_q;
  logic [7:0]         xb_q;
  logic               take;

  assign take        = active_i && rx_valid_i;
  assign pkt_valid_o = take && (idx_q == IDX_W'(PKT_LEN-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= '0;
      btn_hold_q <= '0;
      btn_q      <= '0;
      xs_q       <= 1'b0;
      ys_q       <= 1'b0;
      xb_q       <= '0;
    end else if (!active_i) begin
      idx_q <= '0;
    end else if (take) begin
      if (pkt_valid_o) begin
        idx_q <= '0;
        btn_q <= btn_hold_q;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
      if (idx_q == '0) begin
        btn_hold_q <= rx_data_i[NUM_BTN-1:0];
        xs_q       <= rx_data_i[BIT_XSIGN];
        ys_q       <= rx_data_i[BIT_YSIGN];
      end
      if (idx_q == IDX_W'(1)) xb_q <= rx_data_i;
    end
  end

  assign btn_o = btn_q;
  assign dx_o  = {xs_q, xb_q};
  assign dy_o  = {ys_q, rx_data_i};

  p_idx_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IDX_W'(PKT_LEN));
  p_btn_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_o |=> $stable(btn_q));
  p_idle_reset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> idx_q == '0);
endmodule

// File: rtl/ps2m_accum.sv
module ps2m_accum #(
  parameter int ACC_W = 16,
  parameter int MOV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             upd_i,
  input  logic [MOV_W-1:0] mov_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam int EXT_W = ACC_W - MOV_W;

  logic [ACC_W-1:0] acc_q, mov_ext;

  assign mov_ext = {{EXT_W{mov_i[MOV_W-1]}}, mov_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (upd_i)   acc_q <= acc_q + mov_ext;
  end

  assign acc_o = acc_q;

  p_clear_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> acc_q == '0);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i && !upd_i |=> $stable(acc_q));
endmodule

// File: rtl/ps2_mouse_stream.sv
module ps2_mouse_stream
  import ps2m_pkg::*;
#(
  parameter int ACC_W = 16,
  localparam int HALF_W = ACC_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              clear_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              btn_left_o,
  output logic              btn_right_o,
  output logic              btn_mid_o,
  output logic [HALF_W-1:0] x_lo_o,
  output logic [HALF_W-1:0] x_hi_o,
  output logic [HALF_W-1:0] y_lo_o,
  output logic [HALF_W-1:0] y_hi_o
);
  localparam int NUM_AXIS = 2;

  logic               stream;
  logic               pkt_valid;
  logic [NUM_BTN-1:0] btn;
  logic [MOV_W-1:0]   mov [NUM_AXIS];
  logic [ACC_W-1:0]   acc [NUM_AXIS];

  ps2m_link_fsm u_link (
    .clk_i, .rst_ni, .enable_i, .rx_valid_i, .rx_data_i, .tx_ready_i,
    .tx_valid_o, .tx_data_o, .stream_o(stream)
  );

  ps2m_pkt_asm u_asm (
    .clk_i, .rst_ni, .active_i(stream), .rx_valid_i, .rx_data_i,
    .pkt_valid_o(pkt_valid), .btn_o(btn), .dx_o(mov[0]), .dy_o(mov[1])
  );

  for (genvar a = 0; a < NUM_AXIS; a++) begin : g_axis
    ps2m_accum #(.ACC_W(ACC_W), .MOV_W(MOV_W)) u_acc (
      .clk_i, .rst_ni, .clear_i, .upd_i(pkt_valid),
      .mov_i(mov[a]), .acc_o(acc[a])
    );
  end

  assign btn_left_o  = btn[0];
  assign btn_right_o = btn[1];
  assign btn_mid_o   = btn[2];
  assign x_lo_o = acc[0][HALF_W-1:0];
  assign x_hi_o = acc[0][ACC_W-1:HALF_W];
  assign y_lo_o = acc[1][HALF_W-1:0];
  assign y_hi_o = acc[1][ACC_W-1:HALF_W];

  p_no_move_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !clear_i |=> $stable({x_hi_o, x_lo_o, y_hi_o, y_lo_o}));
endmodule

// File: tb/ps2_mouse_stream_test.sv
module ps2_mouse_stream_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic enable_i = 0, clear_i = 0, rx_valid_i = 0, tx_ready_i = 0;
  logic [7:0] rx_data_i = '0;
  logic tx_valid_o, btn_left_o, btn_right_o, btn_mid_o;
  logic [7:0] tx_data_o, x_lo_o, x_hi_o, y_lo_o, y_hi_o;

  int total = 0, bad = 0;
  logic [15:0] ex = '0, ey = '0;
  logic [2:0]  eb = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_mouse_stream uut (
    .clk_i(clk), .rst_ni, .enable_i, .clear_i, .rx_valid_i, .rx_data_i,
    .tx_ready_i, .tx_valid_o, .tx_data_o, .btn_left_o, .btn_right_o,
    .btn_mid_o, .x_lo_o, .x_hi_o, .y_lo_o, .y_hi_o
  );

  function automatic logic [15:0] sext9(input logic s, input logic [7:0] v);
    return {{8{s}}, v};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    check({x_hi_o, x_lo_o} == ex, {tag, " X"}, {x_hi_o, x_lo_o}, ex);
    check({y_hi_o, y_lo_o} == ey, {tag, " Y"}, {y_hi_o, y_lo_o}, ey);
    check({btn_mid_o, btn_right_o, btn_left_o} == eb, {tag, " BTN"},
          {btn_mid_o, btn_right_o, btn_left_o}, eb);
  endtask

  task automatic put_byte(input logic [7:0] b);
    rx_valid_i = 1; rx_data_i = b;
    @(negedge clk);
    rx_valid_i = 0;
  endtask

  task automatic put_pkt(input logic [7:0] b0, b1, b2, input bit model);
    put_byte(b0); put_byte(b1); put_byte(b2);
    if (model) begin
      eb = b0[2:0];
      ex = ex + sext9(b0[4], b1);
      ey = ey + sext9(b0[5], b2);
    end
  endtask

  task automatic start_link(input int hold);
    enable_i = 1;
    @(negedge clk);
    enable_i = 0;
    check(tx_valid_o == 1'b1, "R2 req", tx_valid_o, 1);
    check(tx_data_o == 8'hF4, "R2 cmd", tx_data_o, 8'hF4);
    for (int i = 0; i < hold; i++) @(negedge clk);
    check(tx_valid_o == 1'b1, "R2 hold", tx_valid_o, 1);
    tx_ready_i = 1;
    @(negedge clk);
    tx_ready_i = 0;
    check(tx_valid_o == 1'b0, "R2 drop", tx_valid_o, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check_outs("R1 reset");
    check(tx_valid_o == 0, "R1 tx", tx_valid_o, 0);

    // R3: bytes while idle are dropped
    put_pkt(8'h17, 8'h40, 8'h22, 0);
    check_outs("R3 idle");

    start_link(2);
    // R3/R4: bytes before ack, incl. a non-ack byte, dropped
    put_pkt(8'h07, 8'h11, 8'h33, 0);
    // R10: enable while waiting ignored
    enable_i = 1; @(negedge clk); enable_i = 0;
    check(tx_valid_o == 0, "R10 wait enable", tx_valid_o, 0);
    check_outs("R3 wait");
    put_byte(8'hFA);
    check_outs("R4 ack consumed");

    // R5/R6/R7/R9 directed signs
    put_pkt(8'h09, 8'h05, 8'h03, 1);   check_outs("R5 R6 R7 pos");
    put_pkt(8'h3A, 8'hFF, 8'h80, 1);   check_outs("R6 R7 neg");
    put_pkt(8'h0C, 8'h00, 8'h00, 1);   check_outs("R5 mid");
    // R5: buttons hold mid-packet
    put_byte(8'h0B);
    check_outs("R5 hold mid");
    put_byte(8'h01); put_byte(8'h01);
    eb = 3'b011; ex = ex + 16'd1; ey = ey + 16'd1;
    check_outs("R5 complete");

    // random packets
    for (int n = 0; n < 60; n++) begin
      logic [7:0] b0, b1, b2;
      b0 = 8'($urandom); b1 = 8'($urandom); b2 = 8'($urandom);
      put_pkt(b0, b1, b2, 1);
      check_outs("R6 R7 rnd");
    end

    // R8 clear, buttons kept
    clear_i = 1; @(negedge clk); clear_i = 0;
    ex = '0; ey = '0;
    check_outs("R8 clear");
    // R8 clear coinciding with packet end
    put_byte(8'h1C); put_byte(8'h44);
    clear_i = 1; put_byte(8'h55); clear_i = 0;
    eb = 3'b100;
    check_outs("R8 clear wins");

    // R9 wrap: +255 X, -256 Y repeated
    for (int n = 0; n < 260; n++) put_pkt(8'h20, 8'hFF, 8'h00, 1);
    check_outs("R9 R6 wrap");
    check(x_hi_o == ex[15:8], "R9 hi", x_hi_o, ex[15:8]);

    // R10 restart discards partial packet
    put_byte(8'h01); put_byte(8'h10);
    start_link(0);
    put_byte(8'h21);
    check_outs("R10 no decode before ack");
    put_byte(8'hFA);
    put_pkt(8'h02, 8'h03, 8'h04, 1);
    check_outs("R10 restart");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule